// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits between a byte-write host port and a page write controller of a nonvolatile memory array. It watches every accepted byte write for fixed address/data command sequences. One three-write sequence arms write protection, or unlocks one load period while protection is on. A six-write sequence removes protection. For every byte write it decides whether the page write controller may take the byte. Command bytes are always withheld from the array.

Byte writes are grouped into load periods. A period opens with the first accepted write and closes once a set number of clock cycles pass with no write. At the close the block pulses a timer-start strobe and holds a busy flag for the length of one internal write cycle. While protection is on and no unlock prefix was given, a period still produces the strobe and the full busy cycle, but no byte is committed. A pending protection change takes effect when the write cycle that follows its command ends.

Top module: `wp_cmd_seq`

## Requirements
- R1: During and right after reset, `prot_on`, `commit_en`, `timer_start` and `wcyc_busy` are all 0.
- R2: The arm sequence is data 0xAA at address 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555. It sets `prot_on` at the end of the write cycle that follows its load period, even when no user byte follows it. `prot_on` stays 0 until then.
- R3: A write that advances or completes a command sequence never raises `commit_en`.
- R4: While unprotected, every accepted non-command write raises `commit_en` for one cycle, in the cycle after the write. `commit_addr` and `commit_data` carry that write's address and data.
- R5: While protected, a load period with no unlock prefix commits nothing. It still yields a `timer_start` pulse and a full busy cycle.
- R6: While protected, the arm sequence used as a prefix lets the user bytes that follow it in the same load period commit.
- R7: The disable sequence is 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555. It clears `prot_on` at the end of the following write cycle. User bytes after it in the same period commit.
- R8: A write that does not match the next expected command step sends the matcher back to idle. That write is handled as ordinary user data.
- R9: A load period closes after GAP_CYCLES consecutive cycles with no write. `timer_start` then pulses for one cycle and `wcyc_busy` stays high for WC_CYCLES cycles. The close also discards any partly matched sequence.
- R10: Writes presented while `wcyc_busy` is high are ignored. They commit nothing, do not advance the matcher and do not open a period.
- R11: Protection persists across any number of load periods until the disable sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Byte write strobe, one per cycle |
| wr_addr | input | 13 | Byte write address |
| wr_data | input | 8 | Byte write data |
| commit_en | output | 1 | Registered: previous cycle's write may be stored |
| commit_addr | output | 13 | Address of the committed byte |
| commit_data | output | 8 | Data of the committed byte |
| timer_start | output | 1 | One-cycle pulse starting the internal write cycle |
| wcyc_busy | output | 1 | Internal write cycle in progress |
| prot_on | output | 1 | Software write protection active |

## Verification
The assertions take for granted that `wr_valid` is a clean single-cycle-per-byte strobe, with address and data valid in that same cycle. They also assume that reset is held for at least one edge before any write. The stimulus drives every input on the falling clock edge, so these hold at each rising edge. It leaves at least GAP_CYCLES quiet cycles plus a full write cycle whenever a scenario needs a period to close. Writes during busy are sent on purpose, to show they are dropped.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_HI = 13'h1555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_LO = 13'h0AAA;
    localparam logic [DATA_W-1:0] KEY_DAT_1   = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DAT_2   = 8'h55;
    localparam logic [DATA_W-1:0] OP_ARM      = 8'hA0;
    localparam logic [DATA_W-1:0] OP_EXTEND   = 8'h80;
    localparam logic [DATA_W-1:0] OP_RELEASE  = 8'h20;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_KEY1,
        MS_KEY2,
        MS_EXT1,
        MS_EXT2,
        MS_EXT3
    } match_st_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_ARM,
        PEND_RELEASE
    } pend_e;

    typedef struct packed {
        logic consumed;
        logic arm_done;
        logic release_done;
    } hit_t;

    function automatic logic step_is(
        input logic [ADDR_W-1:0] a,
        input logic [DATA_W-1:0] d,
        input logic [ADDR_W-1:0] ea,
        input logic [DATA_W-1:0] ed
    );
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/wpseq_match.sv
module wpseq_match
    import wpseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              flush,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output hit_t              hit
);

    match_st_e st_q, st_d;

    always_comb begin
        st_d = MS_IDLE;
        hit  = '0;
        unique case (st_q)
            MS_IDLE: begin
                if (step_is(addr, data, KEY_ADDR_HI, KEY_DAT_1)) begin
                    st_d = MS_KEY1;
                    hit.consumed = 1'b1;
                end
            end
            MS_KEY1: begin
                if (step_is(addr, data, KEY_ADDR_LO, KEY_DAT_2)) begin
                    st_d = MS_KEY2;
                    hit.consumed = 1'b1;
                end
            end
            MS_KEY2: begin
                if (step_is(addr, data, KEY_ADDR_HI, OP_ARM)) begin
                    hit.consumed = 1'b1;
                    hit.arm_done = 1'b1;
                end else if (step_is(addr, data, KEY_ADDR_HI, OP_EXTEND)) begin
                    st_d = MS_EXT1;
                    hit.consumed = 1'b1;
                end
            end
            MS_EXT1: begin
                if (step_is(addr, data, KEY_ADDR_HI, KEY_DAT_1)) begin
                    st_d = MS_EXT2;
                    hit.consumed = 1'b1;
                end
            end
            MS_EXT2: begin
                if (step_is(addr, data, KEY_ADDR_LO, KEY_DAT_2)) begin
                    st_d = MS_EXT3;
                    hit.consumed = 1'b1;
                end
            end
            MS_EXT3: begin
                if (step_is(addr, data, KEY_ADDR_HI, OP_RELEASE)) begin
                    hit.consumed     = 1'b1;
                    hit.release_done = 1'b1;
                end
            end
            default: st_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q <= MS_IDLE;
        end else if (wr_go) begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wpseq_window.sv
module wpseq_window #(
    parameter int GAP_CYCLES = 16,
    parameter int WC_CYCLES  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    output logic accept,
    output logic closing,
    output logic finishing,
    output logic busy
);

    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int WW = $clog2(WC_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
    localparam logic [WW-1:0] WC_LAST  = WW'(WC_CYCLES - 1);

    logic          open_q;
    logic [GW-1:0] gap_q;
    logic [WW-1:0] wc_q;

    assign accept    = wr_req && !busy;
    assign closing   = !busy && !wr_req && open_q && (gap_q == GAP_LAST);
    assign finishing = busy && (wc_q == WC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            gap_q  <= '0;
            wc_q   <= '0;
            busy   <= 1'b0;
        end else if (busy) begin
            if (finishing) begin
                busy <= 1'b0;
                wc_q <= '0;
            end else begin
                wc_q <= wc_q + 1'b1;
            end
        end else if (accept) begin
            open_q <= 1'b1;
            gap_q  <= '0;
        end else if (closing) begin
            open_q <= 1'b0;
            gap_q  <= '0;
            busy   <= 1'b1;
            wc_q   <= '0;
        end else if (open_q) begin
            gap_q <= gap_q + 1'b1;
        end
    end

endmodule

// File: rtl/wpseq_prot.sv
module wpseq_prot
    import wpseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  hit_t hit,
    input  logic closing,
    input  logic finishing,
    output logic prot_on,
    output logic unlocked
);

    pend_e pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_on  <= 1'b0;
            unlocked <= 1'b0;
            pend_q   <= PEND_NONE;
        end else begin
            if (accept && hit.arm_done) begin
                pend_q   <= PEND_ARM;
                unlocked <= 1'b1;
            end else if (accept && hit.release_done) begin
                pend_q   <= PEND_RELEASE;
                unlocked <= 1'b1;
            end else if (closing) begin
                unlocked <= 1'b0;
            end
            if (finishing) begin
                unique case (pend_q)
                    PEND_ARM:     prot_on <= 1'b1;
                    PEND_RELEASE: prot_on <= 1'b0;
                    default:      prot_on <= prot_on;
                endcase
                pend_q <= PEND_NONE;
            end
        end
    end

endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
    import wpseq_pkg::*;
#(
    parameter int GAP_CYCLES = 16,
    parameter int WC_CYCLES  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              timer_start,
    output logic              wcyc_busy,
    output logic              prot_on
);

    logic accept, closing, finishing, unlocked, cmd_byte, allow;
    hit_t hit;

    wpseq_window #(
        .GAP_CYCLES(GAP_CYCLES),
        .WC_CYCLES (WC_CYCLES)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_valid),
        .accept   (accept),
        .closing  (closing),
        .finishing(finishing),
        .busy     (wcyc_busy)
    );

    wpseq_match u_match (
        .clk  (clk),
        .rst  (rst),
        .wr_go(accept),
        .flush(closing),
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    wpseq_prot u_prot (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .hit      (hit),
        .closing  (closing),
        .finishing(finishing),
        .prot_on  (prot_on),
        .unlocked (unlocked)
    );

    assign cmd_byte = hit.consumed;
    assign allow    = accept && !cmd_byte && (!prot_on || unlocked);

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_en   <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
            timer_start <= 1'b0;
        end else begin
            commit_en   <= allow;
            timer_start <= closing;
            if (allow) begin
                commit_addr <= wr_addr;
                commit_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/wpseq_chk.sv
module wpseq_chk (
    input logic clk,
    input logic rst,
    input logic wr_valid,
    input logic accept,
    input logic cmd_byte,
    input logic unlocked,
    input logic commit_en,
    input logic timer_start,
    input logic wcyc_busy,
    input logic prot_on
);

    a_r3_cmd_withheld: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_byte) |=> !commit_en);

    a_r4_open_commits: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd_byte && !prot_on) |=> commit_en);

    a_r5_locked_plain: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd_byte && prot_on && !unlocked) |=> !commit_en);

    a_r10_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wcyc_busy) |=> !commit_en);

    a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
        timer_start |-> wcyc_busy);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        timer_start |=> !timer_start);

    a_r2_prot_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_on) |-> ($past(wcyc_busy) && !wcyc_busy));

endmodule

bind wp_cmd_seq wpseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .accept     (accept),
    .cmd_byte   (cmd_byte),
    .unlocked   (unlocked),
    .commit_en  (commit_en),
    .timer_start(timer_start),
    .wcyc_busy  (wcyc_busy),
    .prot_on    (prot_on)
);

// File: tb/sim_wp_cmd_seq.sv
`timescale 1ns/1ps
module sim_wp_cmd_seq;

    localparam int GAP = 16;
    localparam int WC  = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        commit_en, timer_start, wcyc_busy, prot_on;
    logic [12:0] commit_addr;
    logic [7:0]  commit_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_st = 0;
    bit m_open = 0, m_busy = 0, m_prot = 0, m_unl = 0;
    int m_gap = 0, m_wc = 0, m_pend = 0;
    bit e_commit = 0, e_ts = 0;
    int e_addr = 0, e_data = 0;

    always #2.5 clk = ~clk;

    wp_cmd_seq #(.GAP_CYCLES(GAP), .WC_CYCLES(WC)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit_en(commit_en), .commit_addr(commit_addr),
        .commit_data(commit_data), .timer_start(timer_start),
        .wcyc_busy(wcyc_busy), .prot_on(prot_on)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // model step: returns 1 when the write is a command step
    function automatic bit cmd_step(input int a, input int d);
        bit c = 0;
        int nx = 0;
        case (m_st)
            0: if (a == 'h1555 && d == 'hAA) begin nx = 1; c = 1; end
            1: if (a == 'h0AAA && d == 'h55) begin nx = 2; c = 1; end
            2: if (a == 'h1555 && d == 'hA0) begin c = 1; m_pend = 1; m_unl = 1; end
               else if (a == 'h1555 && d == 'h80) begin nx = 3; c = 1; end
            3: if (a == 'h1555 && d == 'hAA) begin nx = 4; c = 1; end
            4: if (a == 'h0AAA && d == 'h55) begin nx = 5; c = 1; end
            5: if (a == 'h1555 && d == 'h20) begin c = 1; m_pend = 2; m_unl = 1; end
            default: ;
        endcase
        m_st = nx;
        return c;
    endfunction

    task automatic model(input bit v, input int a, input int d);
        bit pr = m_prot;
        bit un = m_unl;
        e_commit = 0;
        e_ts = 0;
        if (m_busy) begin
            if (m_wc == WC - 1) begin
                m_busy = 0;
                m_wc = 0;
                if (m_pend == 1) m_prot = 1;
                if (m_pend == 2) m_prot = 0;
                m_pend = 0;
            end else m_wc++;
        end else if (v) begin
            m_open = 1;
            m_gap = 0;
            if (!cmd_step(a, d) && (!pr || un)) begin
                e_commit = 1; e_addr = a; e_data = d;
            end
        end else if (m_open) begin
            if (m_gap == GAP - 1) begin
                m_open = 0; m_gap = 0; m_busy = 1; m_wc = 0;
                e_ts = 1; m_st = 0; m_unl = 0;
            end else m_gap++;
        end
    endtask

    task automatic cyc(input bit v, input int a, input int d);
        @(negedge clk);
        wr_valid = v;
        wr_addr  = 13'(a);
        wr_data  = 8'(d);
        model(v, a, d);
        @(posedge clk);
        #1;
        check(cur_req, commit_en, e_commit, "commit_en");
        if (e_commit) begin
            check(cur_req, commit_addr, e_addr, "commit_addr");
            check(cur_req, commit_data, e_data, "commit_data");
        end
        check(cur_req, timer_start, e_ts, "timer_start");
        check(cur_req, wcyc_busy, m_busy, "wcyc_busy");
        check(cur_req, prot_on, m_prot, "prot_on");
    endtask

    task automatic wr(input int a, input int d);
        cyc(1, a, d);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    task automatic arm_seq();
        wr('h1555, 'hAA); wr('h0AAA, 'h55); wr('h1555, 'hA0);
    endtask

    initial begin
        int ts_seen;
        repeat (3) @(posedge clk);
        #1;
        check("R1", prot_on, 0, "prot_on in reset");
        check("R1", commit_en, 0, "commit_en in reset");
        @(negedge clk);
        rst = 0;
        #1;
        check("R1", timer_start, 0, "timer_start after reset");
        check("R1", wcyc_busy, 0, "wcyc_busy after reset");

        // R4 / R9: unprotected plain writes
        cur_req = "R4";
        wr('h0010, 'h11); wr('h0011, 'h22); wr('h0012, 'h33);
        cur_req = "R9";
        quiet(GAP + WC + 4);

        // R2: arm with no user bytes
        cur_req = "R2";
        arm_seq();
        quiet(GAP + 2);
        check("R2", prot_on, 0, "prot_on before write cycle ends");
        quiet(WC + 2);
        check("R2", prot_on, 1, "prot_on after arm cycle");

        // R5 / R11: protected plain writes still run a dummy cycle
        cur_req = "R5";
        ts_seen = 0;
        wr('h0100, 'h5A); wr('h0101, 'hA5);
        for (int i = 0; i < GAP + WC + 4; i++) begin
            cyc(0, 0, 0);
            if (timer_start) ts_seen++;
        end
        check("R5", ts_seen, 1, "dummy timer_start count");
        check("R11", prot_on, 1, "protection persists");

        // R6 / R3: prefix then user data commits, command bytes withheld
        cur_req = "R6";
        arm_seq();
        wr('h1555, 'h77); wr('h0200, 'h44);
        quiet(GAP + WC + 4);

        // R8: broken prefix under protection, then user byte
        cur_req = "R8";
        wr('h1555, 'hAA); wr('h0AAA, 'h55); wr('h1554, 'hA0); wr('h0300, 'h12);
        quiet(GAP + WC + 4);

        // R9: gap splits a sequence
        cur_req = "R9";
        wr('h1555, 'hAA); wr('h0AAA, 'h55);
        quiet(GAP + WC + 2);
        wr('h1555, 'hA0); wr('h0301, 'h13);
        quiet(GAP + 1);

        // R10: prefix sent during busy is ignored
        cur_req = "R10";
        arm_seq();
        quiet(WC);
        wr('h0302, 'h14);
        quiet(GAP + WC + 4);

        // R7: disable sequence with trailing data
        cur_req = "R7";
        wr('h1555, 'hAA); wr('h0AAA, 'h55); wr('h1555, 'h80);
        wr('h1555, 'hAA); wr('h0AAA, 'h55); wr('h1555, 'h20);
        wr('h0400, 'hC3);
        quiet(GAP + WC + 4);
        check("R7", prot_on, 0, "prot_on after release");

        // R8: unprotected mismatch becomes user data
        cur_req = "R8";
        wr('h1555, 'hAA); wr('h0AAA, 'h77); wr('h0500, 'h01);
        cur_req = "R3";
        arm_seq();
        quiet(GAP + WC + 4);
        check("R2", prot_on, 1, "re-armed");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule